// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Selectable Bit Clock

This block is a full-duplex asynchronous serial port. Its transmit and receive paths are independent. Each has its own shift register, bit counter and parity logic. Both paths run from one oversampling tick, and sixteen ticks make one bit period. The tick comes from one of three places: an internal divider whose ratio is set in the mode register, rising edges on an external clock pin, or one-cycle pulses from a reload timer elsewhere on the chip.

Software configures the block through a small register port:
- The mode register selects the tick source and the divider ratio, and holds the two pin-enable bits.
- The control register sets the data length, parity, stop length and the path enables, and carries the error-clear bit.
- The status register shows the flags and holds both interrupt enables.
- Two data registers carry the characters, one for each direction.

Writes act at the clock edge where `reg_wr` is high. Reads are combinational. A read strobe on the receive data register is the only read with a side effect.

The transmit holding register behaves like a one-deep stream: the tx-empty flag is its ready signal. A write while it is clear has no effect. The host must observe tx-empty before writing, because there is no stall.

Top module: `serial_port_core`

## Requirements
- R1: Mode bits [1:0] select the tick source:
  - 0: the internal divider, one tick every `DIV_BASE << mode[3:2]` cycles.
  - 1: one tick per rising edge of `ext_clk`, after a two-flop synchroniser.
  - 2: one tick per cycle in which `tmr_tick` is high.
  - 3: no ticks at all.
  One bit period is 16 ticks.
- R2: A transmit frame starts on a tick, with the holding register full (status bit 4 = 0) and transmit enabled (ctrl bit 4). The line carries a low start bit, then the data LSB first, then the optional parity bit, then the high stop bit(s). The line is high when idle.
- R3: Frame format is set in the control register:
  - bit 3: 1 selects 8 data bits, 0 selects 7.
  - bit 0: parity enable.
  - bit 1: parity polarity, 1 for odd, 0 for even.
  - bit 2: 1 selects two stop bits.
- R4: Writing TDATA (address 4) fills the holding register and clears tx-empty (status bit 4). A write while tx-empty is 0 is ignored. Tx-empty sets again when the character moves into the shifter.
- R5: `tx_irq` is high when the transmit interrupt enable (status bit 6) is set, tx-empty is set and no frame is in flight (status bit 7 = 0).
- R6: After a falling edge, the receiver samples the line again 8 ticks later. The start bit is accepted only if the line is still low there; a shorter low pulse is ignored. Later bits are sampled every 16 ticks. The character goes to RXDATA (address 3), with bit 7 read as 0 in 7-bit mode, and rx-full (status bit 3) sets.
- R7: A read strobe on RXDATA clears rx-full. A frame that completes while rx-full is set, and is not read in that cycle, sets overrun (status bit 1) and keeps the old character. A frame that completes in the cycle of such a read stores the new character without an overrun.
- R8: A parity mismatch sets status bit 0. A low first stop bit sets the framing error, status bit 2.
- R9: Writing ctrl with bit 6 set clears all three error flags. An error that is being set in the same cycle stays set.
- R10: `rx_irq` is high when the receive interrupt enable (status bit 5) is set and rx-full or any error flag is set.
- R11: With ctrl bit 5 clear, the receiver ignores the line. With ctrl bit 4 clear, no transmit frame starts.
- R12: Mode bit 4 drives `txd_oe` and mode bit 5 drives `sck_oe`. `sck_o` is low in the first half of each transmitted bit period and high otherwise.
- R13: After reset:
  - the registers read 0, except status, which reads 0x10;
  - `txd_o` and `sck_o` are high;
  - both interrupt requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on RXDATA only) |
| reg_addr | input | 3 | Register address: 0 mode, 1 ctrl, 2 status, 3 rx data, 4 tx data |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data |
| ext_clk | input | 1 | External tick clock, asynchronous |
| tmr_tick | input | 1 | Tick pulse from a reload timer, synchronous |
| rxd | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| txd_oe | output | 1 | Output enable for the transmit pin |
| sck_o | output | 1 | Bit-rate clock for the clock pin |
| sck_oe | output | 1 | Output enable for the clock pin |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Two events can land in the same cycle: a receive frame completing at its stop-bit sample, and a host action on the receive side. That host action is either a read of RXDATA or an error-clear write.

The bench first times one frame from a tick-aligned start to the rise of `rx_irq`. It then repeats the same frame with the host access placed exactly on that completion edge.

Two outcomes are judged:
- With the read: the old character is returned, the new one is stored, and no overrun appears.
- With the clear: the parity error of the completing frame is still set.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    SRC_DIV = 2'd0,
    SRC_EXT = 2'd1,
    SRC_TMR = 2'd2,
    SRC_OFF = 2'd3
  } clk_src_e;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic stop2;
    logic len8;
  } frame_cfg_t;

  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_RXD  = 3'd3;
  localparam logic [2:0] A_TXD  = 3'd4;
endpackage

// File: rtl/sp_tick_sel.sv
module sp_tick_sel
  import sp_pkg::*;
#(
  parameter int DIV_BASE  = 4,
  parameter int DIV_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  clk_src_e             src,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic                 ext_clk,
  input  logic                 tmr_tick,
  output logic                 tick
);
  localparam int MAX_LIM = DIV_BASE << ((1 << DIV_SEL_W) - 1);
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic [CNT_W-1:0] cnt, lim;
  logic             div_tick;
  logic [2:0]       ext_sync;

  assign lim      = CNT_W'(DIV_BASE) << div_sel;
  assign div_tick = (cnt >= lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (src != SRC_DIV || div_tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[1:0], ext_clk};
  end

  always_comb begin
    unique case (src)
      SRC_DIV: tick = div_tick;
      SRC_EXT: tick = ext_sync[1] & ~ext_sync[2];
      SRC_TMR: tick = tmr_tick;
      default: tick = 1'b0;
    endcase
  end

  // R1
  ext_single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_EXT && tick) |=> !tick);
endmodule

// File: rtl/sp_tx.sv
module sp_tx
  import sp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  frame_cfg_t        cfg,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              txd,
  output logic              sck,
  output logic              tdre,
  output logic              busy
);
  localparam int FW = DATA_W + 4;
  localparam int LW = $clog2(FW + 1);
  localparam int SW = $clog2(OSR);

  logic [DATA_W-1:0] hold;
  logic [FW-1:0]     frame, shreg;
  logic [LW-1:0]     flen, left;
  logic [SW-1:0]     sub;
  logic              load;

  always_comb begin : build
    logic [DATA_W-1:0] d;
    int p;
    d = hold;
    if (!cfg.len8) d[DATA_W-1] = 1'b0;
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (cfg.len8 || i < DATA_W - 1) frame[1+i] = d[i];
    end
    p = cfg.len8 ? DATA_W + 1 : DATA_W;
    if (cfg.par_en) begin
      frame[p] = (^d) ^ cfg.par_odd;
      p++;
    end
    p    = p + (cfg.stop2 ? 2 : 1);
    flen = LW'(p);
  end

  assign load = tick && !busy && !tdre && en;
  assign sck  = busy ? sub[SW-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= '0;
      tdre  <= 1'b1;
      busy  <= 1'b0;
      txd   <= 1'b1;
      shreg <= '0;
      left  <= '0;
      sub   <= '0;
    end else begin
      if (wr && tdre) begin
        hold <= wdata;
        tdre <= 1'b0;
      end
      if (load) begin
        tdre  <= 1'b1;
        busy  <= 1'b1;
        txd   <= frame[0];
        shreg <= frame >> 1;
        left  <= flen - 1'b1;
        sub   <= '0;
      end else if (busy && tick) begin
        sub <= sub + 1'b1;
        if (sub == SW'(OSR - 1)) begin
          if (left == '0) begin
            busy <= 1'b0;
            txd  <= 1'b1;
          end else begin
            txd   <= shreg[0];
            shreg <= shreg >> 1;
            left  <= left - 1'b1;
          end
        end
      end
    end
  end

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd && $past(tick));
  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R4
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !tdre) |=> $stable(hold));
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  frame_cfg_t        cfg,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam int SW = $clog2(OSR);
  localparam int LW = $clog2(DATA_W + 3);
  localparam int IW = $clog2(DATA_W);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_e;

  rx_st_e            st;
  logic [1:0]        sync;
  logic              line;
  logic [SW-1:0]     sub;
  logic [LW-1:0]     pos, dlen;
  logic [DATA_W-1:0] sh;
  logic              par_s;

  assign line = sync[1];
  assign dlen = cfg.len8 ? LW'(DATA_W) : LW'(DATA_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      sub   <= '0;
      pos   <= '0;
      sh    <= '0;
      par_s <= 1'b0;
      done  <= 1'b0;
      data  <= '0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st <= RX_IDLE;
      end else if (tick) begin
        unique case (st)
          RX_IDLE: if (!line) begin
            st  <= RX_START;
            sub <= '0;
          end
          RX_START: begin
            if (line) begin
              st <= RX_IDLE;
            end else if (sub == SW'(OSR / 2 - 1)) begin
              st  <= RX_BITS;
              sub <= '0;
              pos <= '0;
              sh  <= '0;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          RX_BITS: begin
            sub <= sub + 1'b1;
            if (sub == SW'(OSR - 1)) begin
              pos <= pos + 1'b1;
              if (pos < dlen) begin
                sh[pos[IW-1:0]] <= line;
              end else if (cfg.par_en && pos == dlen) begin
                par_s <= line;
              end else begin
                st   <= RX_IDLE;
                done <= 1'b1;
                data <= sh;
                perr <= cfg.par_en && (par_s != ((^sh) ^ cfg.par_odd));
                ferr <= !line;
              end
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R6
  start_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_BITS && $past(st) == RX_START) |-> $past(!line));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/serial_port_core.sv
module serial_port_core
  import sp_pkg::*;
#(
  parameter int DIV_BASE  = 4,
  parameter int DIV_SEL_W = 2,
  parameter int DATA_W    = 8,
  parameter int OSR       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_clk,
  input  logic              tmr_tick,
  input  logic              rxd,
  output logic              txd_o,
  output logic              txd_oe,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              tx_irq,
  output logic              rx_irq
);
  clk_src_e             src_q;
  logic [DIV_SEL_W-1:0] div_q;
  logic                 txd_oe_q, sck_oe_q;
  frame_cfg_t           cfg_q;
  logic                 tx_en_q, rx_en_q, rx_ie_q, tx_ie_q;
  logic                 pe_q, ore_q, fre_q, rdrf_q;
  logic [DATA_W-1:0]    rdata_q;

  logic                 tick, tx_wr, tdre, tx_busy;
  logic                 rx_done, rx_perr, rx_ferr;
  logic [DATA_W-1:0]    rx_data;
  logic                 wr_mode, wr_ctrl, wr_stat, rd_rx, clr;

  assign wr_mode = reg_wr && reg_addr == A_MODE;
  assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
  assign wr_stat = reg_wr && reg_addr == A_STAT;
  assign tx_wr   = reg_wr && reg_addr == A_TXD;
  assign rd_rx   = reg_rd && reg_addr == A_RXD;
  assign clr     = wr_ctrl && reg_wdata[6];

  sp_tick_sel #(.DIV_BASE(DIV_BASE), .DIV_SEL_W(DIV_SEL_W)) i_tick (
    .clk, .rst_n, .src(src_q), .div_sel(div_q),
    .ext_clk, .tmr_tick, .tick
  );

  sp_tx #(.DATA_W(DATA_W), .OSR(OSR)) i_tx (
    .clk, .rst_n, .tick, .en(tx_en_q), .cfg(cfg_q),
    .wr(tx_wr), .wdata(reg_wdata),
    .txd(txd_o), .sck(sck_o), .tdre, .busy(tx_busy)
  );

  sp_rx #(.DATA_W(DATA_W), .OSR(OSR)) i_rx (
    .clk, .rst_n, .tick, .en(rx_en_q), .cfg(cfg_q), .rxd,
    .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= SRC_DIV;
      div_q    <= '0;
      txd_oe_q <= 1'b0;
      sck_oe_q <= 1'b0;
      cfg_q    <= '0;
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      rx_ie_q  <= 1'b0;
      tx_ie_q  <= 1'b0;
    end else begin
      if (wr_mode) begin
        src_q    <= clk_src_e'(reg_wdata[1:0]);
        div_q    <= reg_wdata[2 +: DIV_SEL_W];
        txd_oe_q <= reg_wdata[4];
        sck_oe_q <= reg_wdata[5];
      end
      if (wr_ctrl) begin
        cfg_q   <= '{par_en: reg_wdata[0], par_odd: reg_wdata[1],
                     stop2: reg_wdata[2], len8: reg_wdata[3]};
        tx_en_q <= reg_wdata[4];
        rx_en_q <= reg_wdata[5];
      end
      if (wr_stat) begin
        rx_ie_q <= reg_wdata[5];
        tx_ie_q <= reg_wdata[6];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_q    <= 1'b0;
      ore_q   <= 1'b0;
      fre_q   <= 1'b0;
      rdrf_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (clr) begin
        pe_q  <= 1'b0;
        ore_q <= 1'b0;
        fre_q <= 1'b0;
      end
      if (rd_rx) rdrf_q <= 1'b0;
      if (rx_done) begin
        if (rdrf_q && !rd_rx) begin
          ore_q <= 1'b1;
        end else begin
          rdata_q <= rx_data;
          rdrf_q  <= 1'b1;
          if (rx_perr) pe_q  <= 1'b1;
          if (rx_ferr) fre_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_MODE: begin
        reg_rdata[1:0]             = src_q;
        reg_rdata[2 +: DIV_SEL_W] = div_q;
        reg_rdata[4]               = txd_oe_q;
        reg_rdata[5]               = sck_oe_q;
      end
      A_CTRL: reg_rdata[5:0] = {rx_en_q, tx_en_q, cfg_q.len8, cfg_q.stop2,
                                cfg_q.par_odd, cfg_q.par_en};
      A_STAT: reg_rdata[7:0] = {tx_busy, tx_ie_q, rx_ie_q, tdre,
                                rdrf_q, fre_q, ore_q, pe_q};
      A_RXD:  reg_rdata      = rdata_q;
      default: reg_rdata     = '0;
    endcase
  end

  assign txd_oe = txd_oe_q;
  assign sck_oe = sck_oe_q;
  assign tx_irq = tx_ie_q && tdre && !tx_busy;
  assign rx_irq = rx_ie_q && (rdrf_q || pe_q || ore_q || fre_q);

  // R7
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ore_q) |-> $stable(rdata_q) && rdrf_q);
  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_done) |=> !rdrf_q);
  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rx_done) |=> !pe_q && !ore_q && !fre_q);
  // R10
  rx_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> rx_ie_q && ($past(rx_done) || $rose(rx_ie_q)));
endmodule

// File: tb/test_serial_port_core.sv
module test_serial_port_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext_clk = 1'b0, tmr_tick = 1'b0, rxd = 1'b1;
  logic       txd_o, txd_oe, sck_o, sck_oe, tx_irq, rx_irq;

  int n_cmp = 0, n_bad = 0;
  int tph = 0;
  bit ext_run = 0;

  always #10 clk = ~clk;

  serial_port_core i_serial_port_core (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .ext_clk, .tmr_tick, .rxd, .txd_o, .txd_oe, .sck_o, .sck_oe,
    .tx_irq, .rx_irq
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // timer tick: one pulse every third cycle
  always @(negedge clk) begin
    tph      <= (tph == 2) ? 0 : tph + 1;
    tmr_tick <= (tph == 2);
  end

  // external clock: period of six cycles while enabled
  initial forever begin
    @(negedge clk);
    if (ext_run) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk); ext_clk = 1'b0; repeat (2) @(negedge clk);
    end
  end

  // ---------------- behavioural transmit model ----------------
  bit   m_q[$];
  bit   m_line = 1, m_act = 0, m_pend = 0, m_txie = 0;
  int   m_sub = 0;
  logic [7:0] m_buf, m_ctrl = 0, m_mode = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_line = 1; m_act = 0; m_pend = 0; m_txie = 0;
      m_sub = 0; m_ctrl = 0; m_mode = 0;
    end else begin
      bit old_pend, tk;
      old_pend = m_pend;
      tk = (m_mode[1:0] == 2) && tmr_tick;
      if (m_act && tk) begin
        m_sub++;
        if (m_sub == 16) begin
          m_sub = 0;
          if (m_q.size() == 0) begin m_act = 0; m_line = 1; end
          else m_line = m_q.pop_front();
        end
      end else if (tk && !m_act && m_pend && m_ctrl[4]) begin
        int dl, ones;
        dl = m_ctrl[3] ? 8 : 7;
        ones = 0;
        m_q.delete();
        m_q.push_back(0);
        for (int i = 0; i < dl; i++) begin m_q.push_back(m_buf[i]); ones += m_buf[i]; end
        if (m_ctrl[0]) m_q.push_back(((ones % 2) == 1) ^ m_ctrl[1]);
        m_q.push_back(1);
        if (m_ctrl[2]) m_q.push_back(1);
        m_line = m_q.pop_front();
        m_act = 1; m_sub = 0; m_pend = 0;
      end
      if (reg_wr && reg_addr == 4 && !old_pend) begin m_pend = 1; m_buf = reg_wdata; end
      if (reg_wr && reg_addr == 1) m_ctrl = reg_wdata;
      if (reg_wr && reg_addr == 0) m_mode = reg_wdata;
      if (reg_wr && reg_addr == 2) m_txie = reg_wdata[6];
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_mode[1:0] == 2) begin
      chk("R2 txd line", txd_o, m_line);
      chk("R5 tx_irq", tx_irq, m_txie && !m_pend && !m_act);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic align();
    do @(negedge clk); while (tph != 0);
  endtask

  task automatic send(input logic [7:0] d, input int dl, input bit pen, input bit odd,
                      input bit badp, input bit bads);
    int ones;
    ones = 0;
    rxd = 0; repeat (48) @(negedge clk);
    for (int i = 0; i < dl; i++) begin
      rxd = d[i]; ones += d[i]; repeat (48) @(negedge clk);
    end
    if (pen) begin
      rxd = (((ones % 2) == 1) ^ odd) ^ badp; repeat (48) @(negedge clk);
    end
    rxd = !bads; repeat (48) @(negedge clk);
    rxd = 1; repeat (48) @(negedge clk);
  endtask

  task automatic wait_tx_idle();
    int n;
    n = 0;
    @(negedge clk);
    while (!tx_irq && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic low_len(output int n);
    int w;
    w = 0;
    while (txd_o && w < 3000) begin @(negedge clk); w++; end
    n = 0;
    while (!txd_o && n < 3000) begin @(negedge clk); n++; end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] v, got;
    int k, n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13 txd", txd_o, 1); chk("R13 sck", sck_o, 1);
    chk("R13 irqs", {tx_irq, rx_irq}, 0);
    rd(2, v); chk("R13 status", v, 8'h10);
    rd(1, v); chk("R13 ctrl", v, 0);

    // timer source, both pins enabled
    wr(0, 8'h32);
    chk("R12 txd_oe", txd_oe, 1); chk("R12 sck_oe", sck_oe, 1);
    wr(2, 8'h60);
    // R2 R3 8N1
    wr(1, 8'h38); wr(4, 8'hA5); wait_tx_idle();
    // R3 7 data bits, even parity, two stops
    wr(1, 8'h35); wr(4, 8'h3C); wait_tx_idle();
    // R4 back-to-back writes, third ignored; 8 data bits odd parity
    wr(1, 8'h3B); wr(4, 8'h81);
    do @(negedge clk); while (tph != 1);
    wr(4, 8'h7E);
    rd(2, v); chk("R4 tx_empty clear when holding full", v[4], 0);
    wr(4, 8'hC3);
    wait_tx_idle();
    // R11 transmit disabled: character waits
    wr(1, 8'h28); wr(4, 8'h5A);
    repeat (200) @(negedge clk);
    chk("R11 txd idle while tx disabled", txd_o, 1);
    rd(2, v); chk("R11 no frame in flight", v[7], 0);
    wr(1, 8'h38); wait_tx_idle();

    // ---------------- receive ----------------
    wr(1, 8'h38);
    align(); send(8'hA5, 8, 0, 0, 0, 0);
    chk("R10 rx_irq on rx_full", rx_irq, 1);
    rd(2, v); chk("R6 rx_full and no errors", v[3:0], 4'h8);
    rd(3, v); chk("R6 data 8N1", v, 8'hA5);
    rd(2, v); chk("R7 read clears rx_full", v[3], 0);
    chk("R10 rx_irq low after read", rx_irq, 0);
    // R3 R6 7 data bits odd parity
    wr(1, 8'h33);
    align(); send(8'hB5, 7, 1, 1, 0, 0);
    rd(3, v); chk("R6 data 7-bit upper bit zero", v, 8'h35);
    rd(2, v); chk("R8 no parity error", v[0], 0);
    // R8 parity error
    align(); send(8'h12, 7, 1, 1, 1, 0);
    rd(2, v); chk("R8 parity error", v[0], 1);
    chk("R10 rx_irq on error", rx_irq, 1);
    rd(3, v);
    wr(1, 8'h73);
    rd(2, v); chk("R9 errors cleared", v[2:0], 0);
    // R8 framing error
    wr(1, 8'h38);
    align(); send(8'h0F, 8, 0, 0, 0, 1);
    rd(2, v); chk("R8 framing error", v[2], 1);
    rd(3, v); wr(1, 8'h78);
    // R7 plain overrun
    align(); send(8'h44, 8, 0, 0, 0, 0);
    align(); send(8'h55, 8, 0, 0, 0, 0);
    rd(2, v); chk("R7 overrun set", v[1], 1);
    rd(3, v); chk("R7 old data kept", v, 8'h44);
    wr(1, 8'h78);
    // R6 short low pulse ignored
    align(); rxd = 0; repeat (12) @(negedge clk); rxd = 1; repeat (600) @(negedge clk);
    rd(2, v); chk("R6 glitch ignored", v[3], 0);
    // R11 receiver disabled
    wr(1, 8'h18);
    align(); send(8'h99, 8, 0, 0, 0, 0);
    rd(2, v); chk("R11 rx disabled no data", v[3], 0);

    // ---------------- coincidences ----------------
    wr(1, 8'h39);
    align();
    k = 0;
    fork
      send(8'h11, 8, 1, 0, 0, 0);
      begin
        while (!rx_irq && k < 2000) begin @(negedge clk); k++; end
      end
    join
    rd(3, v); chk("R6 data 8E1", v, 8'h11);
    align(); send(8'h22, 8, 1, 0, 0, 0);
    align();
    fork
      send(8'h33, 8, 1, 0, 0, 0);
      begin
        repeat (k - 1) @(negedge clk);
        reg_rd = 1; reg_addr = 3; #1 got = reg_rdata;
        @(negedge clk); reg_rd = 0;
      end
    join
    chk("R7 read on completion returns old", got, 8'h22);
    rd(2, v); chk("R7 no overrun on coincident read", v[1], 0);
    chk("R7 rx_full after coincident read", v[3], 1);
    rd(3, v); chk("R7 new data stored", v, 8'h33);
    align();
    fork
      send(8'h44, 8, 1, 0, 1, 0);
      begin
        repeat (k - 1) @(negedge clk);
        reg_wr = 1; reg_addr = 1; reg_wdata = 8'h79;
        @(negedge clk); reg_wr = 0;
      end
    join
    rd(2, v); chk("R9 error set wins over clear", v[0], 1);
    rd(3, v); wr(1, 8'h79);
    rd(2, v); chk("R9 later clear works", v[0], 0);

    // ---------------- other tick sources ----------------
    wr(1, 8'h38);
    wr(0, 8'h14);
    chk("R12 sck_oe off", sck_oe, 0); chk("R12 txd_oe on", txd_oe, 1);
    wr(4, 8'hFF);
    low_len(n);
    chk("R1 divider start bit length", n, 128);
    wait_tx_idle();
    wr(4, 8'hFF);
    n = 0;
    while (txd_o && n < 3000) begin @(negedge clk); n++; end
    repeat (10) @(negedge clk);
    chk("R12 sck low first half", sck_o, 0);
    repeat (60) @(negedge clk);
    chk("R12 sck high second half", sck_o, 1);
    wait_tx_idle();
    wr(0, 8'h31); ext_run = 1;
    wr(4, 8'hFF);
    low_len(n);
    chk("R1 external clock start bit length", n, 96);
    wait_tx_idle();
    ext_run = 0;
    wr(0, 8'h33); wr(4, 8'h00);
    repeat (300) @(negedge clk);
    chk("R1 no source no frame", txd_o, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule